// File: doc/BRIEF.md
# Descending Data Stack Pointer Unit

This block holds the pointer of a byte-wide data stack that shares one data RAM with a program stack growing upward from address zero. The data stack grows downward instead. A push first steps the pointer down and then writes the byte at the new address. A pop reads the byte at the current address and then steps the pointer up. Because the pointer starts at zero, the first push after reset wraps around and lands at the highest RAM address. That keeps the data stack clear of the program stack for as long as the two do not meet.

The block drives the RAM address, write enable and write data for the present cycle. It expects a RAM with a synchronous read, and it returns the popped byte one clock after the pop request, marked by a valid pulse. Firmware moves the stack by exchanging the accumulator with the pointer. The pointer takes the accumulator value and the old pointer comes back on a dedicated output. A cycle that requests more than one operation changes nothing and raises a one-cycle error pulse.

Top module: `dstk_unit`

## Requirements
- R1: After reset the pointer is 0, so the idle RAM address is 0x00. ramWe, popValid and errPulse are 0, and swapOut is 0.
- R2: A lone push drives ramWe=1, ramAddr=pointer-1 and ramWrData=pushData in the same cycle. The pointer then becomes pointer-1.
- R3: A push while the pointer is 0x00 writes to address 0xFF and leaves the pointer at 0xFF.
- R4: A lone pop drives ramAddr=pointer with ramWe=0 in the same cycle, and the pointer then becomes pointer+1. In the next cycle popValid is 1 for one cycle, and popData carries the byte the RAM returns for that address.
- R5: A pop while the pointer is 0xFF reads address 0xFF and leaves the pointer at 0x00 (arithmetic wraps modulo 256).
- R6: A lone swap loads the pointer with swapIn. From the next cycle swapOut shows the pointer value held before the swap, and it keeps that value until the next swap.
- R7: A cycle with two or three of pushReq, popReq and swapReq set performs nothing. ramWe stays 0, the pointer and swapOut keep their values, and popValid stays 0 in the next cycle. errPulse is 1 in the next cycle only.
- R8: In a cycle with no request, ramAddr shows the pointer, ramWe is 0 and the pointer holds. popValid and errPulse are 0 in any cycle that does not follow a lone pop or a conflicting request, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push one byte |
| popReq | input | 1 | Pop one byte |
| swapReq | input | 1 | Exchange pointer with swapIn |
| pushData | input | DATA_W | Byte to push |
| swapIn | input | ADDR_W | Accumulator value for the exchange |
| ramRdData | input | DATA_W | RAM read data, one clock after the address |
| ramAddr | output | ADDR_W | RAM address for this cycle |
| ramWe | output | 1 | RAM write enable |
| ramWrData | output | DATA_W | RAM write data |
| popData | output | DATA_W | Popped byte, valid with popValid |
| popValid | output | 1 | Popped byte present this cycle |
| swapOut | output | ADDR_W | Pointer value before the last swap |
| errPulse | output | 1 | Conflicting requests in the previous cycle |

## Verification
The bench builds the unit with its default 8-bit address and data widths, which matches the 256-byte RAM of the intended system. With that size, random pushes, pops and swaps with random accumulator values reach both wrap points (0x00 down to 0xFF, and 0xFF up to 0x00) within a short run. They also reach every pointer value. A bench-side shadow of the RAM predicts each popped byte. Directed steps pin the first push after reset, a pop at 0xFF and every conflicting request mix.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
  // Decoded operation handed from control to datapath; at most one of
  // push/pop/swap is set, clash marks a rejected multi-request cycle.
  typedef struct packed {
    logic push;
    logic pop;
    logic swap;
    logic clash;
  } stackOp_t;
endpackage

// File: rtl/dstk_ctrl.sv
module dstk_ctrl
  import dstk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pushReq,
  input  logic     popReq,
  input  logic     swapReq,
  output stackOp_t op,
  output logic     popValid,
  output logic     errPulse
);
  logic [1:0] reqCount;

  always_comb begin
    reqCount = {1'b0, pushReq} + {1'b0, popReq} + {1'b0, swapReq};
    op.clash = (reqCount > 2'd1);
    op.push  = pushReq & ~op.clash;
    op.pop   = popReq  & ~op.clash;
    op.swap  = swapReq & ~op.clash;
  end

  // Synchronous RAM read returns data one clock later: flag it then.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      popValid <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      popValid <= op.pop;
      errPulse <= op.clash;
    end
  end

  AST_POP_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    popValid |-> $past(popReq && !pushReq && !swapReq)); // R4
  AST_ERR_AFTER_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    ((pushReq && popReq) || (pushReq && swapReq) || (popReq && swapReq)) |=> (errPulse && !popValid)); // R7
  AST_ERR_ONLY_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(({1'b0, pushReq} + {1'b0, popReq} + {1'b0, swapReq}) > 2'd1)); // R8
endmodule

// File: rtl/dstk_path.sv
module dstk_path
  import dstk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackOp_t          op,
  input  logic [DATA_W-1:0] pushData,
  input  logic [ADDR_W-1:0] swapIn,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWrData,
  output logic [DATA_W-1:0] popData,
  output logic [ADDR_W-1:0] swapOut
);
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PTR_TOP = '1;

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] ptrDec;
  logic [ADDR_W-1:0] ptrInc;

  // Modulo-2^ADDR_W arithmetic; pre-decrement for push, post-increment for pop.
  assign ptrDec    = ptr - PTR_ONE;
  assign ptrInc    = ptr + PTR_ONE;
  assign ramAddr   = op.push ? ptrDec : ptr;
  assign ramWe     = op.push;
  assign ramWrData = pushData;
  assign popData   = ramRdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      swapOut <= '0;
    end else if (op.push) begin
      ptr <= ptrDec;
    end else if (op.pop) begin
      ptr <= ptrInc;
    end else if (op.swap) begin
      ptr     <= swapIn;
      swapOut <= ptr;
    end
  end

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rstN)
    op.push |=> (ptr == $past(ptr) - PTR_ONE)); // R2
  AST_PUSH_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (op.push && ptr == '0) |-> (ramAddr == PTR_TOP && ramWe)); // R3
  AST_POP_INC: assert property (@(posedge clk) disable iff (!rstN)
    op.pop |=> (ptr == $past(ptr) + PTR_ONE)); // R4
  AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rstN)
    op.swap |=> (ptr == $past(swapIn) && swapOut == $past(ptr))); // R6
  AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    op.clash |=> ($stable(ptr) && $stable(swapOut))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(op.push || op.pop || op.swap) |=> $stable(ptr)); // R8
endmodule

// File: rtl/dstk_unit.sv
module dstk_unit
  import dstk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              swapReq,
  input  logic [DATA_W-1:0] pushData,
  input  logic [ADDR_W-1:0] swapIn,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWrData,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic [ADDR_W-1:0] swapOut,
  output logic              errPulse
);
  stackOp_t op;

  dstk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pushReq  (pushReq),
    .popReq   (popReq),
    .swapReq  (swapReq),
    .op       (op),
    .popValid (popValid),
    .errPulse (errPulse)
  );

  dstk_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .op        (op),
    .pushData  (pushData),
    .swapIn    (swapIn),
    .ramRdData (ramRdData),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .ramWrData (ramWrData),
    .popData   (popData),
    .swapOut   (swapOut)
  );

  AST_WE_LONE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (pushReq && !popReq && !swapReq)); // R7
endmodule

// File: tb/dstk_unit_tb.sv
module dstk_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0, swapReq = 1'b0;
  logic [DW-1:0] pushData = '0;
  logic [AW-1:0] swapIn = '0;
  logic [DW-1:0] ramRdData;
  logic [AW-1:0] ramAddr;
  logic ramWe;
  logic [DW-1:0] ramWrData, popData;
  logic popValid, errPulse;
  logic [AW-1:0] swapOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  dstk_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq), .swapReq(swapReq),
    .pushData(pushData), .swapIn(swapIn), .ramRdData(ramRdData),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWrData(ramWrData),
    .popData(popData), .popValid(popValid), .swapOut(swapOut), .errPulse(errPulse)
  );

  // Synchronous-read RAM model driven by the DUT.
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] rdQ = '0;
  assign ramRdData = rdQ;
  always @(posedge clk) begin
    if (ramWe) ram[ramAddr] <= ramWrData;
    rdQ <= ram[ramAddr];
  end

  // Reference model state.
  logic [DW-1:0] refMem [DEPTH];
  logic [AW-1:0] expPtr = '0;
  logic [AW-1:0] expSw = '0;
  logic expPv = 1'b0, expErr = 1'b0;
  logic [DW-1:0] expPd = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int countReq(input bit p, input bit q, input bit s);
    return int'(p) + int'(q) + int'(s);
  endfunction

  // One cycle: check last cycle's registered results, drive, check
  // combinational RAM outputs, then advance the model.
  task automatic step(input bit p, input bit q, input bit s,
                      input logic [DW-1:0] d, input logic [AW-1:0] acc);
    int n;
    logic [AW-1:0] expAddr;
    @(negedge clk);
    chk(popValid == expPv, "R4/R8 popValid", popValid, expPv);
    if (expPv) chk(popData == expPd, "R4 popData", popData, expPd);
    chk(errPulse == expErr, "R7/R8 errPulse", errPulse, expErr);
    chk(swapOut == expSw, "R6 swapOut", swapOut, expSw);
    pushReq = p; popReq = q; swapReq = s; pushData = d; swapIn = acc;
    #1;
    n = countReq(p, q, s);
    expAddr = (n == 1 && p) ? expPtr - 1'b1 : expPtr;
    chk(ramAddr == expAddr, "R2/R4/R8 ramAddr", ramAddr, expAddr);
    chk(ramWe == (n == 1 && p), "R2/R7 ramWe", ramWe, (n == 1 && p));
    if (n == 1 && p) chk(ramWrData == d, "R2 ramWrData", ramWrData, d);
    expPv = 1'b0;
    expErr = (n > 1);
    if (n == 1) begin
      if (p) begin
        expPtr = expPtr - 1'b1;
        refMem[expPtr] = d;
      end else if (q) begin
        expPd = refMem[expPtr];
        expPv = 1'b1;
        expPtr = expPtr + 1'b1;
      end else begin
        expSw = expPtr;
        expPtr = acc;
      end
    end
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ram[i] = '0;
      refMem[i] = '0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    chk(ramAddr == 8'h00, "R1 ramAddr", ramAddr, 0);
    chk(ramWe == 1'b0, "R1 ramWe", ramWe, 0);
    chk(popValid == 1'b0, "R1 popValid", popValid, 0);
    chk(errPulse == 1'b0, "R1 errPulse", errPulse, 0);
    chk(swapOut == 8'h00, "R1 swapOut", swapOut, 0);
    rstN = 1'b1;
    idle();
    // R3: first push wraps to 0xFF
    step(1'b1, 1'b0, 1'b0, 8'hA5, '0);
    chk(expPtr == 8'hFF, "R3 model ptr", expPtr, 8'hFF);
    step(1'b1, 1'b0, 1'b0, 8'h3C, '0);
    // R4: pop back both bytes
    step(1'b0, 1'b1, 1'b0, '0, '0);
    step(1'b0, 1'b1, 1'b0, '0, '0);
    idle();
    // R6: swap pointer to 0xFF, R5: pop at 0xFF wraps to 0
    step(1'b0, 1'b0, 1'b1, '0, 8'hFF);
    step(1'b0, 1'b1, 1'b0, '0, '0);
    idle();
    // R6: swap returns 0x00 after the wrap
    step(1'b0, 1'b0, 1'b1, '0, 8'h20);
    idle();
    // R7: every conflicting mix
    step(1'b1, 1'b1, 1'b0, 8'h11, 8'h40);
    step(1'b1, 1'b0, 1'b1, 8'h22, 8'h41);
    step(1'b0, 1'b1, 1'b1, 8'h33, 8'h42);
    step(1'b1, 1'b1, 1'b1, 8'h44, 8'h43);
    idle();
    idle();
    // Random mix
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 15));
      if (r < 6)       step(1'b1, 1'b0, 1'b0, DW'($urandom), '0);
      else if (r < 11) step(1'b0, 1'b1, 1'b0, '0, '0);
      else if (r == 11) step(1'b0, 1'b0, 1'b1, '0, AW'($urandom));
      else if (r == 12) step(1'($urandom), 1'b1, 1'($urandom), DW'($urandom), AW'($urandom));
      else             idle();
    end
    idle();
    idle();
    finishRun();
  end
endmodule